// File: doc/BRIEF.md
# Battery Charge Ledger

This block keeps the digital charge record of a rechargeable battery. Upstream logic turns the sensed current and the self-discharge timebase into single-cycle count strobes. The block turns those strobes into three counters. The available-charge counter `nac` is the present contents of the battery. The drain counter `dcr` is the charge removed since the battery was last full. The capacity counter `lmd` is the learned full level.

Charge strobes are weighted by an efficiency factor. The factor depends on the temperature band and on whether charging is fast or trickle. The weighting runs through a fractional accumulator in hundredths, so only part of each charge strobe reaches `nac`.

The capacity is relearned only after a qualified run from full to empty. The block tracks that qualification with a flag. A host write port can load the available-charge and capacity counters directly, which is useful for pack initialisation and test.

Top module: `charge_ledger`

## Requirements
- R1: A weighted charge increment raises `nac` by one, but never above `lmd`. A discharge or self-discharge strobe lowers `nac` by one, but never below 0.
- R2: Every discharge strobe raises `dcr` by one. A self-discharge strobe raises `dcr` only while `nac` is nonzero.
- R3: `dcr` stops at all-ones and does not wrap. It is cleared on any cycle that starts with `nac` equal to `lmd`. A strobe in such a cycle counts up from 0.
- R4: A discharge strobe while `nac` equals `lmd` sets `validDischarge`. This set wins over any clear condition in the same cycle.
- R5: `validDischarge` clears in three cases: when SD_LIMIT self-discharge strobes have been counted since `nac` last equalled `lmd`; on a valid charge; or when `emptyLatched` rises while `tempCode` is 3 or lower.
- R6: A valid charge that arrives while both `emptyLatched` and `validDischarge` are set does three things. It copies `dcr` into `lmd`, clears `nac` to 0, and drops the increment of that cycle.
- R7: Each charge strobe adds a factor in hundredths to an accumulator. Each carry past 100 gives one `nac` increment. The fast/trickle factors are 95/80 for codes 0–6, 90/75 for codes 7–8, and 85/70 for codes 9 and up.
- R8: The first charge strobe after reset or after a discharge strobe starts a charge and uses the fast factor. At each `rateTick` while charging, `fastCharge` becomes 1 if the window since the previous tick held at least RATE_MIN charge strobes, counting a strobe in the tick cycle; otherwise it becomes 0.
- R9: During reset the block loads `lmd` with `fullCount`. It sets `nac` to 0, or to `fullCount` when `presetFullN` is low. It clears `dcr`, `validDischarge` and `emptyLatched`, and sets `fastCharge`.
- R10: A host write to address 0 loads `nac` and a write to address 1 loads `lmd`, in both cases winning over counting. Writes to addresses 2 and 3 change nothing.
- R11: When strobes coincide in one cycle, only one is taken, in the order discharge, then charge, then self-discharge.
- R12: `emptyLatched` sets while `edvLevel` is high. A valid charge clears it. A valid charge is the VALID_CHG-th weighted increment since the charge started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| chgStrobe | input | 1 | One raw charge count |
| dchgStrobe | input | 1 | One discharge count |
| selfStrobe | input | 1 | One self-discharge count |
| rateTick | input | 1 | End of the charge-rate window |
| tempCode | input | 4 | Temperature step code, 10 °C per step |
| edvLevel | input | 1 | Cell voltage below end-of-discharge level |
| fullCount | input | W | Programmed full count |
| presetFullN | input | 1 | Low: reset starts full |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | 2 | Host write address |
| hostData | input | W | Host write data |
| nac | output | W | Available charge counter |
| dcr | output | W | Drain counter |
| lmd | output | W | Learned capacity |
| validDischarge | output | 1 | Present discharge qualifies for learning |
| fastCharge | output | 1 | Fast charge efficiency selected |
| emptyLatched | output | 1 | End-of-discharge latched |

## Verification
The bench builds the block with a 16-bit counter width and RATE_MIN of 2. It shortens VALID_CHG to 16 and SD_LIMIT to 64. With these lengths a valid charge completes within seventeen strobes and the self-discharge disqualification within sixty-four. Full learn cycles, cold and self-discharge disqualification are therefore cheap to reach. The 16-bit width keeps the drain counter's all-ones stop reachable in about sixty-six thousand back-to-back discharge strobes.

// File: rtl/charge_ledger_pkg.sv
package charge_ledger_pkg;

  localparam logic [1:0] ADDR_NAC = 2'd0;
  localparam logic [1:0] ADDR_LMD = 2'd1;

  typedef struct packed {
    logic incNac;
    logic decNac;
    logic incDcr;
    logic learn;
    logic wrNac;
    logic wrLmd;
  } ledgerCmd_t;

  // Efficiency factor in hundredths from temperature step and rate regime.
  function automatic logic [6:0] chargeFactor(input logic [3:0] code, input logic fast);
    logic [6:0] f;
    if (code <= 4'd6)      f = fast ? 7'd95 : 7'd80;
    else if (code <= 4'd8) f = fast ? 7'd90 : 7'd75;
    else                   f = fast ? 7'd85 : 7'd70;
    return f;
  endfunction

endpackage

// File: rtl/charge_ledger_ctrl.sv
module charge_ledger_ctrl
  import charge_ledger_pkg::*;
#(
  parameter int VALID_CHG = 256,
  parameter int SD_LIMIT  = 4096,
  parameter int RATE_MIN  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chgStrobe,
  input  logic       dchgStrobe,
  input  logic       selfStrobe,
  input  logic       rateTick,
  input  logic [3:0] tempCode,
  input  logic       edvLevel,
  input  logic       hostWe,
  input  logic [1:0] hostAddr,
  input  logic       atFull,
  input  logic       nacZero,
  output ledgerCmd_t cmd,
  output logic       vdq,
  output logic       fastChg,
  output logic       edvFlag
);
  localparam int RUN_W = $clog2(VALID_CHG + 1);
  localparam int SD_W  = $clog2(SD_LIMIT + 1);
  localparam int WIN_W = $clog2(RATE_MIN + 1) + 1;

  logic             evDchg, evChg, evSelf;
  logic             chargeActive;
  logic [6:0]       accFrac;
  logic [7:0]       accSum;
  logic             carry;
  logic [RUN_W-1:0] runCnt;
  logic [SD_W-1:0]  sdCnt;
  logic [WIN_W-1:0] winCnt, winEff;
  logic             validEvt, sdHit, coldEdv;

  // One event per cycle: discharge, then charge, then self-discharge.
  assign evDchg = dchgStrobe;
  assign evChg  = chgStrobe & ~dchgStrobe;
  assign evSelf = selfStrobe & ~dchgStrobe & ~chgStrobe;

  assign accSum = {1'b0, accFrac} + {1'b0, chargeFactor(tempCode, fastChg | ~chargeActive)};
  assign carry  = accSum >= 8'd100;

  assign validEvt = evChg & carry & (runCnt == RUN_W'(VALID_CHG - 1));
  assign sdHit    = evSelf & ~atFull & (sdCnt == SD_W'(SD_LIMIT - 1));
  assign coldEdv  = edvLevel & ~edvFlag & (tempCode <= 4'd3);
  assign winEff   = winCnt + WIN_W'(evChg);

  always_comb begin
    cmd        = '0;
    cmd.incNac = evChg & carry;
    cmd.decNac = evDchg | evSelf;
    cmd.incDcr = evDchg | (evSelf & ~nacZero);
    cmd.learn  = validEvt & edvFlag & vdq;
    cmd.wrNac  = hostWe & (hostAddr == ADDR_NAC);
    cmd.wrLmd  = hostWe & (hostAddr == ADDR_LMD);
  end

  // Fractional accumulator for charge efficiency.
  always_ff @(posedge clk) begin
    if (!rstN)      accFrac <= '0;
    else if (evChg) accFrac <= carry ? 7'(accSum - 8'd100) : accSum[6:0];
  end

  // Charge session, rate window and fast/trickle regime.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chargeActive <= 1'b0;
      fastChg      <= 1'b1;
      winCnt       <= '0;
    end else begin
      if (evDchg)     chargeActive <= 1'b0;
      else if (evChg) chargeActive <= 1'b1;
      if (rateTick) begin
        winCnt <= '0;
        if (chargeActive | evChg) fastChg <= (winEff >= WIN_W'(RATE_MIN));
      end else begin
        if (evChg && winCnt < WIN_W'(RATE_MIN)) winCnt <= winCnt + 1'b1;
        if (evChg && !chargeActive) fastChg <= 1'b1;
      end
    end
  end

  // Weighted increments since the charge started.
  always_ff @(posedge clk) begin
    if (!rstN)                                           runCnt <= '0;
    else if (evDchg)                                     runCnt <= '0;
    else if (cmd.incNac && runCnt < RUN_W'(VALID_CHG))   runCnt <= runCnt + 1'b1;
  end

  // Self-discharge strobes since the battery was last full.
  always_ff @(posedge clk) begin
    if (!rstN)                                      sdCnt <= '0;
    else if (atFull)                                sdCnt <= '0;
    else if (evSelf && sdCnt < SD_W'(SD_LIMIT))     sdCnt <= sdCnt + 1'b1;
  end

  // Qualification and empty latch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vdq     <= 1'b0;
      edvFlag <= 1'b0;
    end else begin
      if (evDchg && atFull)                 vdq <= 1'b1;
      else if (sdHit || validEvt || coldEdv) vdq <= 1'b0;
      if (validEvt)      edvFlag <= 1'b0;
      else if (edvLevel) edvFlag <= 1'b1;
    end
  end

  p_vdq_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dchgStrobe && atFull) |=> vdq);
  p_fast_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chgStrobe && !dchgStrobe && !chargeActive && !rateTick) |=> fastChg);
  p_learn_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.learn |=> (!vdq && !edvFlag));
  p_cold_edv_r5: assert property (@(posedge clk) disable iff (!rstN)
    (edvLevel && !edvFlag && tempCode <= 4'd3 && !(dchgStrobe && atFull)) |=> !vdq);
  p_one_event_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({evDchg, evChg, evSelf}) <= 1);

endmodule

// File: rtl/charge_ledger_dp.sv
module charge_ledger_dp
  import charge_ledger_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ledgerCmd_t   cmd,
  input  logic [W-1:0] fullCount,
  input  logic         presetFullN,
  input  logic [W-1:0] hostData,
  output logic [W-1:0] nac,
  output logic [W-1:0] dcr,
  output logic [W-1:0] lmd,
  output logic         atFull,
  output logic         nacZero
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] dcrBase;

  assign atFull  = (nac == lmd);
  assign nacZero = (nac == '0);
  assign dcrBase = atFull ? '0 : dcr;

  always_ff @(posedge clk) begin
    if (!rstN)                         nac <= presetFullN ? '0 : fullCount;
    else if (cmd.wrNac)                nac <= hostData;
    else if (cmd.learn)                nac <= '0;
    else if (cmd.incNac && nac < lmd)  nac <= nac + 1'b1;
    else if (cmd.decNac && !nacZero)   nac <= nac - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lmd <= fullCount;
    else if (cmd.wrLmd) lmd <= hostData;
    else if (cmd.learn) lmd <= dcr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           dcr <= '0;
    else if (cmd.incDcr) dcr <= (dcrBase == CNT_MAX) ? CNT_MAX : dcrBase + 1'b1;
    else                 dcr <= dcrBase;
  end

  p_nac_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incNac && !cmd.wrNac && !cmd.learn && nac >= lmd) |=> $stable(nac));
  p_nac_floor_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decNac && !cmd.wrNac && !cmd.learn && nacZero) |=> (nac == '0));
  p_dcr_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dcr == CNT_MAX && !atFull) |=> (dcr == CNT_MAX));
  p_dcr_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (atFull && !cmd.incDcr) |=> (dcr == '0));

endmodule

// File: rtl/charge_ledger.sv
module charge_ledger
  import charge_ledger_pkg::*;
#(
  parameter int W         = 16,
  parameter int VALID_CHG = 256,
  parameter int SD_LIMIT  = 4096,
  parameter int RATE_MIN  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         chgStrobe,
  input  logic         dchgStrobe,
  input  logic         selfStrobe,
  input  logic         rateTick,
  input  logic [3:0]   tempCode,
  input  logic         edvLevel,
  input  logic [W-1:0] fullCount,
  input  logic         presetFullN,
  input  logic         hostWe,
  input  logic [1:0]   hostAddr,
  input  logic [W-1:0] hostData,
  output logic [W-1:0] nac,
  output logic [W-1:0] dcr,
  output logic [W-1:0] lmd,
  output logic         validDischarge,
  output logic         fastCharge,
  output logic         emptyLatched
);
  ledgerCmd_t cmd;
  logic       atFull, nacZero;

  charge_ledger_ctrl #(
    .VALID_CHG(VALID_CHG), .SD_LIMIT(SD_LIMIT), .RATE_MIN(RATE_MIN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .chgStrobe(chgStrobe), .dchgStrobe(dchgStrobe),
    .selfStrobe(selfStrobe), .rateTick(rateTick), .tempCode(tempCode),
    .edvLevel(edvLevel), .hostWe(hostWe), .hostAddr(hostAddr),
    .atFull(atFull), .nacZero(nacZero), .cmd(cmd), .vdq(validDischarge),
    .fastChg(fastCharge), .edvFlag(emptyLatched)
  );

  charge_ledger_dp #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fullCount(fullCount),
    .presetFullN(presetFullN), .hostData(hostData), .nac(nac), .dcr(dcr),
    .lmd(lmd), .atFull(atFull), .nacZero(nacZero)
  );

endmodule

// File: tb/test_charge_ledger.sv
module test_charge_ledger;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         chgStrobe = 0, dchgStrobe = 0, selfStrobe = 0, rateTick = 0;
  logic [3:0]   tempCode = 4'd5;
  logic         edvLevel = 0;
  logic [W-1:0] fullCount = 16'd1000;
  logic         presetFullN = 1'b1;
  logic         hostWe = 0;
  logic [1:0]   hostAddr = 0;
  logic [W-1:0] hostData = 0;
  logic [W-1:0] nac, dcr, lmd;
  logic         validDischarge, fastCharge, emptyLatched;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  charge_ledger #(.W(W), .VALID_CHG(16), .SD_LIMIT(64), .RATE_MIN(2)) i_charge_ledger (
    .clk(clk), .rstN(rstN), .chgStrobe(chgStrobe), .dchgStrobe(dchgStrobe),
    .selfStrobe(selfStrobe), .rateTick(rateTick), .tempCode(tempCode),
    .edvLevel(edvLevel), .fullCount(fullCount), .presetFullN(presetFullN),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData), .nac(nac),
    .dcr(dcr), .lmd(lmd), .validDischarge(validDischarge),
    .fastCharge(fastCharge), .emptyLatched(emptyLatched)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doReset(input logic [W-1:0] pfc, input logic preset);
    @(negedge clk);
    rstN = 0; fullCount = pfc; presetFullN = preset;
    chgStrobe = 0; dchgStrobe = 0; selfStrobe = 0; rateTick = 0; edvLevel = 0; hostWe = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
  endtask

  task automatic chg(input int n);
    for (int i = 0; i < n; i++) begin chgStrobe = 1; @(negedge clk); chgStrobe = 0; end
  endtask
  task automatic dchg(input int n);
    for (int i = 0; i < n; i++) begin dchgStrobe = 1; @(negedge clk); dchgStrobe = 0; end
  endtask
  task automatic selfd(input int n);
    for (int i = 0; i < n; i++) begin selfStrobe = 1; @(negedge clk); selfStrobe = 0; end
  endtask
  task automatic tick();
    rateTick = 1; @(negedge clk); rateTick = 0;
  endtask
  task automatic hostWrite(input logic [1:0] a, input logic [W-1:0] d);
    hostWe = 1; hostAddr = a; hostData = d; @(negedge clk); hostWe = 0;
  endtask

  task automatic t_reset();
    doReset(16'd1000, 1'b1);
    check("R9 nac", nac, 0);
    check("R9 lmd", lmd, 1000);
    check("R9 dcr", dcr, 0);
    check("R9 vdq", validDischarge, 0);
    check("R9 fast", fastCharge, 1);
    check("R9 empty", emptyLatched, 0);
    doReset(16'd700, 1'b0);
    check("R9 preset nac", nac, 700);
  endtask

  task automatic t_fast(input logic [3:0] t, input int expNac);
    doReset(16'd1000, 1'b1);
    tempCode = t;
    chg(20);
    check("R7 fast factor", nac, expNac);
  endtask

  task automatic t_trickle(input logic [3:0] t, input int fastF, input int slowF, input int n);
    doReset(16'd1000, 1'b1);
    tempCode = t;
    chg(1);
    tick();
    check("R8 trickle after slow window", fastCharge, 0);
    chg(n);
    check("R7 trickle factor", nac, (fastF + n * slowF) / 100);
  endtask

  task automatic t_rate_back();
    doReset(16'd1000, 1'b1);
    tempCode = 4'd5;
    chg(1); tick();
    chg(5);
    check("R7 mixed", nac, 4);
    chg(3); tick();
    check("R8 fast again", fastCharge, 1);
    check("R7 mixed more", nac, 7);
  endtask

  task automatic t_cap_floor();
    doReset(16'd10, 1'b1);
    tempCode = 4'd5;
    chg(30);
    check("R1 cap at lmd", nac, 10);
    check("R3 dcr clear at full", dcr, 0);
    selfd(3);
    check("R2 self counts", dcr, 3);
    check("R1 self decrement", nac, 7);
    check("R4 self no qualify", validDischarge, 0);
    dchg(7);
    check("R1 floor", nac, 0);
    selfd(2);
    check("R2 self ignored at zero", dcr, 10);
    dchg(2);
    check("R2 discharge at zero", dcr, 12);
    check("R1 floor hold", nac, 0);
  endtask

  task automatic t_learn();
    doReset(16'd40, 1'b0);
    tempCode = 4'd5;
    dchg(1);
    check("R4 vdq set", validDischarge, 1);
    check("R3 count from zero", dcr, 1);
    dchg(39);
    dchg(2);
    check("R2 dcr total", dcr, 42);
    edvLevel = 1; @(negedge clk); edvLevel = 0;
    check("R12 empty set", emptyLatched, 1);
    check("R5 warm edv keeps", validDischarge, 1);
    chg(16);
    check("R6 before valid", nac, 15);
    chg(1);
    check("R6 lmd learned", lmd, 42);
    check("R6 nac cleared", nac, 0);
    check("R5 vdq after valid", validDischarge, 0);
    check("R12 empty cleared", emptyLatched, 0);
  endtask

  task automatic t_cold();
    doReset(16'd40, 1'b0);
    dchg(1);
    tempCode = 4'd2;
    edvLevel = 1; @(negedge clk); edvLevel = 0;
    check("R5 cold clears", validDischarge, 0);
    chg(17);
    check("R6 no learn", lmd, 40);
    check("R12 cleared by valid", emptyLatched, 0);
    tempCode = 4'd5;
  endtask

  task automatic t_sd();
    doReset(16'd100, 1'b0);
    dchg(1);
    selfd(63);
    check("R5 sd below limit", validDischarge, 1);
    selfd(1);
    check("R5 sd limit", validDischarge, 0);
    check("R1 self nac", nac, 35);
  endtask

  task automatic t_valid_chg();
    doReset(16'd100, 1'b0);
    tempCode = 4'd5;
    dchg(31);
    chg(16);
    check("R5 before valid", validDischarge, 1);
    chg(1);
    check("R5 valid charge clears", validDischarge, 0);
    check("R1 increments kept", nac, 85);
  endtask

  task automatic t_dcr_sat();
    doReset(16'd100, 1'b1);
    hostWrite(2'd1, 16'hFFFF);
    hostWrite(2'd0, 16'hFFFF);
    check("R10 lmd write", lmd, 16'hFFFF);
    check("R10 nac write", nac, 16'hFFFF);
    dchgStrobe = 1;
    repeat (65537) @(negedge clk);
    dchgStrobe = 0;
    check("R3 dcr saturate", dcr, 16'hFFFF);
    check("R1 nac emptied", nac, 0);
    hostWrite(2'd0, 16'hFFFF);
    @(negedge clk);
    check("R3 clear at full", dcr, 0);
    hostWrite(2'd2, 16'd5);
    hostWrite(2'd3, 16'd6);
    check("R10 ignored nac", nac, 16'hFFFF);
    check("R10 ignored lmd", lmd, 16'hFFFF);
  endtask

  task automatic t_priority();
    doReset(16'd40, 1'b0);
    chgStrobe = 1; dchgStrobe = 1; @(negedge clk); chgStrobe = 0; dchgStrobe = 0;
    check("R11 discharge wins", nac, 39);
    check("R11 discharge counted", dcr, 1);
    chgStrobe = 1; selfStrobe = 1; @(negedge clk); chgStrobe = 0; selfStrobe = 0;
    check("R11 self dropped", nac, 39);
    check("R11 self dropped dcr", dcr, 1);
  endtask

  initial begin
    t_reset();
    t_fast(4'd5, 19);
    t_fast(4'd7, 18);
    t_fast(4'd12, 17);
    t_trickle(4'd5, 95, 80, 5);
    t_trickle(4'd8, 90, 75, 4);
    t_trickle(4'd11, 85, 70, 3);
    t_rate_back();
    t_cap_floor();
    t_learn();
    t_cold();
    t_sd();
    t_valid_chg();
    t_priority();
    t_dcr_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule